// File: doc/BRIEF.md
# Masked Packed Integer-to-Half Converter

This block takes a vector of signed 32-bit integer lanes and turns each lane into an IEEE 754 half-precision value in one registered step. A vector-length code selects 4, 8 or 16 active lanes (128, 256 or 512 source bits). Each 32-bit source lane lands as a 16-bit result in the destination lane with the same index, so the result occupies half the source width. Every destination bit above that half is cleared.

A per-lane mask picks which lanes receive a new value. When masking is on, each lane whose mask bit is clear either takes zero or keeps the old destination value, depending on a zeroing flag. A broadcast flag makes every lane convert lane 0 when the operand comes from memory. For a register operand at the 512-bit length, the same flag instead selects a rounding mode embedded in the operation over the globally configured one. Two sticky flags gather overflow and inexact events across operations. An operation with a malformed reserved field is rejected.

Top module: `i2h_pack_conv`

## Requirements
- R1: Vector-length code 0, 1 and 2 gives 4, 8 and 16 active lanes. Source bits [32j+31:32j] feed destination bits [16j+15:16j]. Every destination bit at or above 16 times the lane count is zero. Inactive lanes raise no flags.
- R2: With masking off (`in_mask_en`=0), every active lane is written with its converted value, whatever the mask holds. With masking on, a lane whose mask bit j is 1 is written with its converted value.
- R3: With masking on and mask bit j clear, active lane j becomes 0x0000 when `in_zeroing`=1. When `in_zeroing`=0 it keeps bits [16j+15:16j] of `in_old_dst`.
- R4: When `in_src_mem`=1 and `in_bcast`=1, every active lane converts source lane 0. When `in_src_mem`=0, the broadcast flag never replicates data.
- R5: The rounding mode is `in_rm_embed` only when `in_src_mem`=0, the vector-length code is 2 and `in_bcast`=1. Otherwise it is `in_rm_global`.
- R6: Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Magnitudes up to 2048 convert exactly. Zero converts to 0x0000. -2147483648 is handled through its unsigned 32-bit magnitude.
- R7: A lane whose rounded magnitude exceeds 65504 overflows and sets both the overflow and inexact sticky flags. Its result is infinity (0x7C00 or 0xFC00) under nearest-even, or under a directed mode pointing away from zero on the value's side. Otherwise the result is 0x7BFF or 0xFBFF.
- R8: The inexact sticky flag sets when any written lane discards a nonzero bit. Both sticky flags clear only at reset. Masked-off lanes raise no flag.
- R9: An operation with `in_rsvd` other than 4'b1111, or with vector-length code 3, is rejected. `out_illegal` is 1 and the destination and flags stay unchanged.
- R10: Each `in_valid` cycle yields `out_valid` one clock later, together with the new destination. After reset the outputs and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation present |
| in_vlen | input | 2 | Vector-length code (0:128, 1:256, 2:512) |
| in_src | input | 512 | Source integer lanes |
| in_src_mem | input | 1 | Operand comes from memory |
| in_bcast | input | 1 | Broadcast / embedded-rounding flag |
| in_mask_en | input | 1 | Masking enabled |
| in_mask | input | 16 | Per-lane mask |
| in_zeroing | input | 1 | Zero masked-off lanes instead of merging |
| in_old_dst | input | 256 | Previous destination contents for merging |
| in_rm_global | input | 2 | Global rounding mode |
| in_rm_embed | input | 2 | Per-operation rounding mode |
| in_rsvd | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Result available |
| out_illegal | output | 1 | Last operation was rejected |
| out_dst | output | 512 | Destination vector |
| out_ovf | output | 1 | Sticky overflow flag |
| out_inx | output | 1 | Sticky inexact flag |

## Verification
The bench builds the block with its default width of 512 bits. With that width all three vector lengths are legal, so the 512-bit-only embedded rounding path can be reached. The clearing of the upper destination half can be observed at each length. Lane stimulus covers mid-point ties and values just below and just above the half-precision limit. It also includes the most negative integer and mixed merge and zero masks. The reference conversion works by repeated scaling and integer division rather than by shifting bits.

// File: rtl/i2h_pkg.sv
`timescale 1ns/1ps
package i2h_pkg;
  localparam int LANE_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rm_e;

  // Returns {overflow, inexact, half_result}
  function automatic logic [17:0] i2h_cvt(input logic [31:0] x, input logic [1:0] rm);
    logic        sgn;
    logic [31:0] mag;
    logic [31:0] kept;
    logic [31:0] rem;
    logic [31:0] half;
    logic        up;
    logic        ovf;
    logic        inx;
    logic        to_inf;
    logic [15:0] h;
    int          p;
    int          sh;
    int          e;
    sgn  = x[31];
    mag  = sgn ? (~x + 32'd1) : x;
    p    = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    up   = 1'b0;
    rem  = '0;
    half = '0;
    if (p <= 10) begin
      kept = mag << (10 - p);
    end else begin
      sh   = p - 10;
      kept = mag >> sh;
      rem  = mag & ((32'd1 << sh) - 32'd1);
      half = 32'd1 << (sh - 1);
      case (rm)
        RM_NEAR: up = (rem > half) || ((rem == half) && kept[0]);
        RM_DOWN: up = sgn && (rem != 0);
        RM_UP:   up = !sgn && (rem != 0);
        default: up = 1'b0;
      endcase
    end
    kept = kept + {31'd0, up};
    e    = p;
    if (kept[11]) begin
      kept = kept >> 1;
      e    = e + 1;
    end
    ovf    = (mag != 0) && (e > 15);
    inx    = (rem != 0) || ovf;
    to_inf = (rm == RM_NEAR) || ((rm == RM_UP) && !sgn) || ((rm == RM_DOWN) && sgn);
    if (mag == 0)   h = 16'h0000;
    else if (ovf)   h = {sgn, to_inf ? 15'h7C00 : 15'h7BFF};
    else            h = {sgn, 5'(e + 15), kept[9:0]};
    return {ovf, inx, h};
  endfunction
endpackage

// File: rtl/i2h_ctl.sv
`timescale 1ns/1ps
module i2h_ctl #(
  parameter int MAXL = 16
) (
  input  logic [1:0]      vlen,
  input  logic            src_mem,
  input  logic            bcast,
  input  logic [1:0]      rm_global,
  input  logic [1:0]      rm_embed,
  input  logic [3:0]      rsvd,
  output logic [1:0]      rm_sel,
  output logic            bcast_eff,
  output logic            accept,
  output logic [MAXL-1:0] lane_live
);
  logic use_embed;
  logic [5:0] nlanes;

  assign use_embed = !src_mem && (vlen == 2'd2) && bcast;
  assign rm_sel    = use_embed ? rm_embed : rm_global;
  assign bcast_eff = src_mem && bcast;
  assign accept    = (rsvd == 4'hF) && (vlen != 2'd3);
  assign nlanes    = 6'd4 << vlen;

  generate
    for (genvar j = 0; j < MAXL; j++) begin : g_live
      assign lane_live[j] = (6'(j) < nlanes);
    end
  endgenerate
endmodule

// File: rtl/i2h_lane.sv
`timescale 1ns/1ps
module i2h_lane
  import i2h_pkg::*;
(
  input  logic [LANE_W-1:0] own_word,
  input  logic [LANE_W-1:0] word0,
  input  logic              bcast_eff,
  input  logic              live,
  input  logic              mask_en,
  input  logic              mask_bit,
  input  logic              zeroing,
  input  logic [HALF_W-1:0] old_half,
  input  logic [1:0]        rm,
  output logic [HALF_W-1:0] res,
  output logic              ovf,
  output logic              inx
);
  logic [LANE_W-1:0] pick;
  logic [17:0]       cv;
  logic              wr;

  assign pick = bcast_eff ? word0 : own_word;
  assign cv   = i2h_cvt(pick, rm);
  assign wr   = live && (!mask_en || mask_bit);

  always_comb begin
    if (!live)        res = '0;
    else if (wr)      res = cv[15:0];
    else if (zeroing) res = '0;
    else              res = old_half;
  end
  assign ovf = wr && cv[17];
  assign inx = wr && cv[16];
endmodule

// File: rtl/i2h_pack_conv.sv
`timescale 1ns/1ps
module i2h_pack_conv
  import i2h_pkg::*;
#(
  parameter int MAXVL = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_vlen,
  input  logic [MAXVL-1:0]           in_src,
  input  logic                       in_src_mem,
  input  logic                       in_bcast,
  input  logic                       in_mask_en,
  input  logic [MAXVL/LANE_W-1:0]    in_mask,
  input  logic                       in_zeroing,
  input  logic [MAXVL/2-1:0]         in_old_dst,
  input  logic [1:0]                 in_rm_global,
  input  logic [1:0]                 in_rm_embed,
  input  logic [3:0]                 in_rsvd,
  output logic                       out_valid,
  output logic                       out_illegal,
  output logic [MAXVL-1:0]           out_dst,
  output logic                       out_ovf,
  output logic                       out_inx
);
  localparam int MAXL  = MAXVL / LANE_W;
  localparam int HALFV = MAXVL / 2;

  logic [1:0]        rm_sel;
  logic              bcast_eff;
  logic              op_ok;
  logic [MAXL-1:0]   lane_live;
  logic [MAXL-1:0]   lane_ovf;
  logic [MAXL-1:0]   lane_inx;
  logic [HALFV-1:0]  lane_res;
  logic              take;

  i2h_ctl #(.MAXL(MAXL)) u_ctl (
    .vlen(in_vlen), .src_mem(in_src_mem), .bcast(in_bcast),
    .rm_global(in_rm_global), .rm_embed(in_rm_embed), .rsvd(in_rsvd),
    .rm_sel(rm_sel), .bcast_eff(bcast_eff), .accept(op_ok), .lane_live(lane_live)
  );

  generate
    for (genvar j = 0; j < MAXL; j++) begin : g_lane
      i2h_lane u_lane (
        .own_word (in_src[j*LANE_W +: LANE_W]),
        .word0    (in_src[LANE_W-1:0]),
        .bcast_eff(bcast_eff),
        .live     (lane_live[j]),
        .mask_en  (in_mask_en),
        .mask_bit (in_mask[j]),
        .zeroing  (in_zeroing),
        .old_half (in_old_dst[j*HALF_W +: HALF_W]),
        .rm       (rm_sel),
        .res      (lane_res[j*HALF_W +: HALF_W]),
        .ovf      (lane_ovf[j]),
        .inx      (lane_inx[j])
      );
    end
  endgenerate

  assign take = in_valid && op_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_dst     <= '0;
      out_ovf     <= 1'b0;
      out_inx     <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && !op_ok;
      if (take) begin
        out_dst <= {{(MAXVL-HALFV){1'b0}}, lane_res};
        out_ovf <= out_ovf | (|lane_ovf);
        out_inx <= out_inx | (|lane_inx);
      end
    end
  end
endmodule

// File: rtl/i2h_pack_conv_chk.sv
`timescale 1ns/1ps
module i2h_pack_conv_chk #(
  parameter int MAXVL = 512,
  parameter int MAXL  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             op_ok,
  input logic [1:0]       in_vlen,
  input logic             in_mask_en,
  input logic [MAXL-1:0]  in_mask,
  input logic             in_zeroing,
  input logic [MAXVL/2-1:0] in_old_dst,
  input logic             out_valid,
  input logic             out_illegal,
  input logic [MAXVL-1:0] out_dst,
  input logic             out_ovf,
  input logic             out_inx
);
  localparam int BASE_BITS = 64;

  a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok) |=> ((out_dst >> (BASE_BITS << $past(in_vlen))) == '0));

  a_r3_merge_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && in_mask_en && !in_zeroing && (in_mask == '0)) |=>
    (out_dst == ({{(MAXVL/2){1'b0}}, $past(in_old_dst)} &
                 ~({MAXVL{1'b1}} << (BASE_BITS << $past(in_vlen))))));

  a_r3_zero_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && in_mask_en && in_zeroing && (in_mask == '0)) |=> (out_dst == '0));

  a_r7_ovf_sets_inx: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_inx);

  a_r8_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_ovf));

  a_r8_sticky_inx: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_inx));

  a_r9_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_ok) |=> (out_illegal && $stable(out_dst) && $stable(out_ovf) && $stable(out_inx)));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
endmodule

bind i2h_pack_conv i2h_pack_conv_chk #(.MAXVL(MAXVL), .MAXL(MAXL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_ok(op_ok), .in_vlen(in_vlen),
  .in_mask_en(in_mask_en), .in_mask(in_mask), .in_zeroing(in_zeroing),
  .in_old_dst(in_old_dst), .out_valid(out_valid), .out_illegal(out_illegal),
  .out_dst(out_dst), .out_ovf(out_ovf), .out_inx(out_inx)
);

// File: tb/tb_i2h_pack_conv.sv
`timescale 1ns/1ps
module tb_i2h_pack_conv;
  localparam int VW = 512;
  localparam int NL = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [1:0]     in_vlen = '0;
  logic [VW-1:0]  in_src = '0;
  logic           in_src_mem = 1'b0;
  logic           in_bcast = 1'b0;
  logic           in_mask_en = 1'b0;
  logic [NL-1:0]  in_mask = '0;
  logic           in_zeroing = 1'b0;
  logic [VW/2-1:0] in_old_dst = '0;
  logic [1:0]     in_rm_global = '0;
  logic [1:0]     in_rm_embed = '0;
  logic [3:0]     in_rsvd = 4'hF;
  logic           out_valid, out_illegal, out_ovf, out_inx;
  logic [VW-1:0]  out_dst;

  int checks = 0;
  int fails  = 0;
  logic [VW-1:0] exp_last = '0;
  logic          exp_ovf = 1'b0;
  logic          exp_inx = 1'b0;

  logic [VW-1:0] q_dst[$];
  logic [2:0]    q_flg[$];
  string         q_tag[$];

  logic [31:0] lanes [NL];

  always #2 clk = ~clk;

  i2h_pack_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vlen(in_vlen), .in_src(in_src),
    .in_src_mem(in_src_mem), .in_bcast(in_bcast), .in_mask_en(in_mask_en), .in_mask(in_mask),
    .in_zeroing(in_zeroing), .in_old_dst(in_old_dst), .in_rm_global(in_rm_global),
    .in_rm_embed(in_rm_embed), .in_rsvd(in_rsvd), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_dst(out_dst), .out_ovf(out_ovf), .out_inx(out_inx)
  );

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: scale down by powers of two, round on the remainder.
  function automatic logic [17:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm);
    longint v, mag, scale, q, r, e;
    bit neg, up, ov, inx;
    logic [15:0] h;
    v = longint'($signed(x));
    neg = (v < 0);
    mag = neg ? -v : v;
    if (mag == 0) return 18'd0;
    scale = 1;
    while (mag >= 2048 * scale) scale = scale * 2;
    q = mag / scale;
    r = mag % scale;
    case (rm)
      2'b00:   up = (2*r > scale) || ((2*r == scale) && (q % 2 == 1));
      2'b01:   up = neg && (r != 0);
      2'b10:   up = !neg && (r != 0);
      default: up = 1'b0;
    endcase
    inx = (r != 0);
    q = q + (up ? 1 : 0);
    v = q * scale;
    ov = (v > 65504);
    if (ov) begin
      inx = 1'b1;
      if (rm == 2'b00 || (rm == 2'b10 && !neg) || (rm == 2'b01 && neg)) h = {neg, 15'h7C00};
      else h = {neg, 15'h7BFF};
    end else begin
      e = 0;
      while ((64'd1 << (e + 1)) <= v) e++;
      if (e >= 10) q = v >> (e - 10); else q = v << (10 - e);
      h = {neg, 5'(e + 15), 10'(q - 1024)};
    end
    return {ov, inx, h};
  endfunction

  function automatic logic [VW-1:0] pack_lanes();
    logic [VW-1:0] s;
    for (int j = 0; j < NL; j++) s[32*j +: 32] = lanes[j];
    return s;
  endfunction

  task automatic do_op(input logic [1:0] vl, input logic mem, input logic bc,
                       input logic men, input logic [NL-1:0] msk, input logic z,
                       input logic [1:0] rmg, input logic [1:0] rme,
                       input logic [3:0] rsv, input string tag);
    logic [VW-1:0] src, expd;
    logic [VW/2-1:0] old;
    logic [1:0] rm;
    logic [17:0] cv;
    logic [31:0] w;
    int kl;
    src = pack_lanes();
    for (int j = 0; j < NL; j++) old[16*j +: 16] = 16'hC000 + 16'(j * 3);
    @(negedge clk);
    in_valid = 1'b1; in_vlen = vl; in_src = src; in_src_mem = mem; in_bcast = bc;
    in_mask_en = men; in_mask = msk; in_zeroing = z; in_old_dst = old;
    in_rm_global = rmg; in_rm_embed = rme; in_rsvd = rsv;
    if (rsv != 4'hF || vl == 2'd3) begin
      q_dst.push_back(exp_last);
      q_flg.push_back({1'b1, exp_ovf, exp_inx});
      q_tag.push_back(tag);
    end else begin
      kl = 4 << vl;
      rm = (!mem && vl == 2'd2 && bc) ? rme : rmg;
      expd = '0;
      for (int j = 0; j < NL; j++) begin
        if (j < kl) begin
          w = (mem && bc) ? src[31:0] : src[32*j +: 32];
          if (!men || msk[j]) begin
            cv = ref_cvt(w, rm);
            expd[16*j +: 16] = cv[15:0];
            exp_ovf = exp_ovf | cv[17];
            exp_inx = exp_inx | cv[16];
          end else if (!z) begin
            expd[16*j +: 16] = old[16*j +: 16];
          end
        end
      end
      exp_last = expd;
      q_dst.push_back(expd);
      q_flg.push_back({1'b0, exp_ovf, exp_inx});
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_dst.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected out_valid actual=1 expected=0");
      end else begin
        logic [VW-1:0] ed;
        logic [2:0] ef;
        string t;
        ed = q_dst.pop_front();
        ef = q_flg.pop_front();
        t  = q_tag.pop_front();
        chk({t, " dst"}, out_dst, ed);
        chk({t, " illegal (R9)"}, VW'(out_illegal), VW'(ef[2]));
        chk({t, " ovf (R7)"}, VW'(out_ovf), VW'(ef[1]));
        chk({t, " inx (R8)"}, VW'(out_inx), VW'(ef[0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset out_valid", VW'(out_valid), '0);
    chk("R10 reset dst", out_dst, '0);
    chk("R10 reset flags", VW'({out_ovf, out_inx, out_illegal}), '0);

    // R1 R6: 4 lanes, exact values, upper lanes would overflow but are inactive
    for (int j = 0; j < NL; j++) lanes[j] = 32'h7EAD_BEEF;
    lanes[0] = 32'd0; lanes[1] = 32'd1; lanes[2] = 32'hFFFF_FFFF; lanes[3] = 32'd2048;
    do_op(2'd0, 0, 0, 0, '0, 0, 2'b00, 2'b00, 4'hF, "R1 R6 vl128 exact");

    // R6: all four rounding modes on ties and off-ties, 8 lanes
    lanes[0] = 32'd2049; lanes[1] = 32'd2051; lanes[2] = -32'sd2049; lanes[3] = -32'sd2051;
    lanes[4] = 32'd4099; lanes[5] = 32'd3000; lanes[6] = 32'd1025; lanes[7] = -32'sd65504;
    for (int m = 0; m < 4; m++)
      do_op(2'd1, 0, 0, 0, '0, 0, 2'(m), 2'(3 - m), 4'hF, "R6 vl256 rounding");

    // R2 R3: masked 16 lanes
    for (int j = 0; j < NL; j++) lanes[j] = 32'(j * 37 - 300);
    do_op(2'd2, 0, 0, 1, 16'hA5C3, 0, 2'b00, 2'b00, 4'hF, "R3 merge mask");
    do_op(2'd2, 0, 0, 1, 16'hA5C3, 1, 2'b00, 2'b00, 4'hF, "R3 zero mask");
    do_op(2'd1, 0, 0, 1, 16'h0000, 0, 2'b00, 2'b00, 4'hF, "R3 merge all off");
    do_op(2'd2, 0, 0, 0, 16'h0000, 1, 2'b00, 2'b00, 4'hF, "R2 mask disabled");

    // R4: broadcast from memory vs register
    for (int j = 0; j < NL; j++) lanes[j] = 32'(j * 1111 + 5);
    lanes[0] = 32'd777;
    do_op(2'd2, 1, 1, 0, '0, 0, 2'b00, 2'b00, 4'hF, "R4 mem broadcast");
    do_op(2'd1, 0, 1, 0, '0, 0, 2'b00, 2'b00, 4'hF, "R4 reg no broadcast");

    // R5: embedded vs global rounding
    for (int j = 0; j < NL; j++) lanes[j] = 32'd2049;
    do_op(2'd2, 0, 1, 0, '0, 0, 2'b11, 2'b10, 4'hF, "R5 embedded used");
    do_op(2'd2, 1, 1, 0, '0, 0, 2'b11, 2'b10, 4'hF, "R5 mem keeps global");
    do_op(2'd1, 0, 1, 0, '0, 0, 2'b11, 2'b10, 4'hF, "R5 vl256 keeps global");

    // R9: rejections leave state untouched
    lanes[0] = 32'd70000;
    do_op(2'd0, 0, 0, 0, '0, 0, 2'b00, 2'b00, 4'hE, "R9 reserved field");
    do_op(2'd3, 0, 0, 0, '0, 0, 2'b00, 2'b00, 4'hF, "R9 bad length");

    // R7 R8: overflow and limits
    lanes[0] = 32'd65520; lanes[1] = 32'd65519; lanes[2] = 32'd100000; lanes[3] = 32'h8000_0000;
    do_op(2'd0, 0, 0, 1, 16'h0004, 0, 2'b11, 2'b00, 4'hF, "R8 masked-off no flags");
    do_op(2'd0, 0, 0, 0, '0, 0, 2'b00, 2'b00, 4'hF, "R7 nearest overflow");
    do_op(2'd0, 0, 0, 0, '0, 0, 2'b11, 2'b00, 4'hF, "R7 toward zero saturate");
    lanes[0] = -32'sd100000; lanes[1] = 32'd100000; lanes[2] = 32'd0; lanes[3] = 32'h8000_0000;
    do_op(2'd0, 0, 0, 0, '0, 0, 2'b01, 2'b00, 4'hF, "R7 toward minus inf");
    do_op(2'd0, 0, 0, 0, '0, 0, 2'b10, 2'b00, 4'hF, "R7 toward plus inf");

    idle(4);
    chk("R10 queue drained", VW'(q_dst.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule